// File: doc/BRIEF.md
# Adaptive Equalizer Row Sequencer

This block is the front end that drives an external triangular QR/Schur processing array used as an adaptive least-squares equalizer. Received samples enter a tapped delay line. Each accepted sample produces one row for the array. The row is the current delay-line contents, newest sample first, which is one row of the Toeplitz convolution matrix of the received signal. The block also supplies the row's mode code and its right-hand-side value.

A session starts when reset is released. In the first cycle the block issues one set-mode row. That row loads the array's diagonal with a parameter value and clears the rest of the array state. A value of zero gives a plain clear. A nonzero value gives a regularized estimator. After that, each row follows the training flag. While the flag is high, rows are issued in orthogonal mode and carry the training symbol, so the array adapts its triangular factor. While the flag is low, rows are issued in linear mode with the row negated and a zero right-hand side. The array then returns the equalized sample on its output port. The filter coefficients stay inside the array and are never read out.

The block tracks which issued rows were payload rows. It raises an output-valid flag, together with the array's output value, exactly one array pipeline latency after each payload row.

Top module: `rls_eq_seq`

## Requirements
- R1: In the first clock cycle after reset release, the block issues exactly one row with mode code 2'b00 (set). Every W1 element of that row equals the INIT_DIAG parameter, and W2 is 0. No further set row follows.
- R2: The delay line is all zeros after reset. The first data rows therefore carry zeros in the taps that no sample has reached yet.
- R3: An accepted sample produces a row in the next cycle. Element k of W1 (bits k*W +: W) equals the sample accepted k samples earlier, with the newest sample at k=0.
- R4: When train_mode is 1 at the time a sample is accepted, the row has mode code 2'b01 (orthogonal), and W2 equals train_sym from that same cycle.
- R5: When train_mode is 0 at the time a sample is accepted, the row has mode code 2'b10 (linear). Every W1 element is the two's-complement negation of the delay-line tap, and W2 is 0.
- R6: row_mode, row_w1 and row_w2 change only in cycles where row_valid is 1. Mode and data always belong to the same row slot.
- R7: eq_valid is 1 exactly LAT cycles after each linear-mode row. It is never 1 because of a set-mode or orthogonal-mode row.
- R8: eq_data equals arr_y while eq_valid is 1, and is 0 otherwise.
- R9: A sample presented in the set-row cycle after reset release is ignored. It produces no data row and does not enter the delay line.
- R10: row_valid is 0 in every cycle in which no sample was accepted in the previous cycle (apart from the set row).

Parameters: W (sample width, default 16), TAPS (delay-line length, default 4), LAT (array latency in cycles, default 3), INIT_DIAG (diagonal value for the set row, default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A received sample is present |
| smp_data | input | W | Received sample, signed |
| train_mode | input | 1 | 1 = training row, 0 = payload row |
| train_sym | input | W | Known training symbol, signed |
| arr_y | input | W | Output port of the external array |
| row_valid | output | 1 | A row is presented to the array this cycle |
| row_mode | output | 2 | 00 set, 01 orthogonal, 10 linear |
| row_w1 | output | TAPS*W | Row elements, newest tap at bits W-1:0 |
| row_w2 | output | W | Right-hand-side element of the row |
| eq_valid | output | 1 | Equalized sample is valid |
| eq_data | output | W | Equalized sample |

## Verification
The assertions check, on every cycle, the invariants that hold locally:
- row fields stay fixed between rows;
- linear rows always carry a zero right-hand side;
- the delay line shifts one tap per accepted sample;
- only a single set row appears after reset;
- eq_data is zero whenever eq_valid is low.

Only the bench scenarios can show the end-to-end behaviour. These cover the newest-first tap order over a stream that starts zero-filled, the exact LAT-cycle placement of eq_valid across a train-to-payload switch, and the value returned through a stand-in array. They also cover the dropping of a sample presented during the set cycle and the regularized diagonal value.

// File: rtl/rls_eq_seq_pkg.sv
package rls_eq_seq_pkg;
   typedef enum logic [1:0] {
      MODE_SET  = 2'b00,
      MODE_ORTH = 2'b01,
      MODE_LIN  = 2'b10
   } arr_mode_e;
endpackage

// File: rtl/eqs_tap_line.sv
module eqs_tap_line #(
   parameter int W    = 16,
   parameter int TAPS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_en,
   input  logic [W-1:0]        din,
   output logic [TAPS*W-1:0]   taps_nxt
);
   localparam int VW = TAPS * W;

   logic [VW-1:0] taps_q;

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      if (k == 0) begin : g_head
         assign taps_nxt[W-1:0] = shift_en ? din : taps_q[W-1:0];
      end else begin : g_body
         assign taps_nxt[k*W +: W] = shift_en ? taps_q[(k-1)*W +: W]
                                              : taps_q[k*W +: W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps_q <= '0;
      else        taps_q <= taps_nxt;
   end

   if (TAPS >= 2) begin : g_chk
      p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
         shift_en |=> taps_q[2*W-1:W] == $past(taps_q[W-1:0]));
   end
   p_newest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> taps_q[W-1:0] == $past(din));
endmodule

// File: rtl/eqs_row_former.sv
module eqs_row_former
   import rls_eq_seq_pkg::*;
#(
   parameter int W         = 16,
   parameter int TAPS      = 4,
   parameter int INIT_DIAG = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                init_fire,
   input  logic                row_fire,
   input  logic                train,
   input  logic [TAPS*W-1:0]   taps_nxt,
   input  logic [W-1:0]        sym,
   output logic                row_valid,
   output arr_mode_e           row_mode,
   output logic [TAPS*W-1:0]   row_w1,
   output logic [W-1:0]        row_w2
);
   localparam int VW = TAPS * W;
   localparam logic [W-1:0] DIAG_W = W'(INIT_DIAG);

   logic [VW-1:0] neg_vec;
   logic [VW-1:0] diag_vec;

   for (genvar k = 0; k < TAPS; k++) begin : g_neg
      assign neg_vec[k*W +: W] = -taps_nxt[k*W +: W];
   end

   if (INIT_DIAG == 0) begin : g_clear
      assign diag_vec = '0;
   end else begin : g_sigma
      assign diag_vec = {TAPS{DIAG_W}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_valid <= 1'b0;
         row_mode  <= MODE_SET;
         row_w1    <= '0;
         row_w2    <= '0;
      end else begin
         row_valid <= init_fire | row_fire;
         if (init_fire) begin
            row_mode <= MODE_SET;
            row_w1   <= diag_vec;
            row_w2   <= '0;
         end else if (row_fire) begin
            if (train) begin
               row_mode <= MODE_ORTH;
               row_w1   <= taps_nxt;
               row_w2   <= sym;
            end else begin
               row_mode <= MODE_LIN;
               row_w1   <= neg_vec;
               row_w2   <= '0;
            end
         end
      end
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_fire || row_fire) |=> !row_valid && $stable(row_mode)
                                    && $stable(row_w1) && $stable(row_w2));
   p_lin_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (row_fire && !train && !init_fire) |=> row_w2 == '0 && row_mode == MODE_LIN);
   p_orth_sym_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (row_fire && train && !init_fire) |=> row_w2 == $past(sym));
endmodule

// File: rtl/eqs_out_tracker.sv
module eqs_out_tracker #(
   parameter int W   = 16,
   parameter int LAT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lin_row,
   input  logic [W-1:0]  arr_y,
   output logic          eq_valid,
   output logic [W-1:0]  eq_data
);
   if (LAT == 1) begin : g_one
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= lin_row;
      end
      assign eq_valid = pend_q;
   end else begin : g_many
      logic [LAT-1:0] pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= '0;
         else        pend_q <= {pend_q[LAT-2:0], lin_row};
      end
      assign eq_valid = pend_q[LAT-1];
   end

   assign eq_data = eq_valid ? arr_y : '0;

   p_eq_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !eq_valid |-> eq_data == '0);
   p_eq_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eq_valid |-> eq_data == arr_y);
endmodule

// File: rtl/rls_eq_seq.sv
module rls_eq_seq
   import rls_eq_seq_pkg::*;
#(
   parameter int W         = 16,
   parameter int TAPS      = 4,
   parameter int LAT       = 3,
   parameter int INIT_DIAG = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [W-1:0]        smp_data,
   input  logic                train_mode,
   input  logic [W-1:0]        train_sym,
   input  logic [W-1:0]        arr_y,
   output logic                row_valid,
   output logic [1:0]          row_mode,
   output logic [TAPS*W-1:0]   row_w1,
   output logic [W-1:0]        row_w2,
   output logic                eq_valid,
   output logic [W-1:0]        eq_data
);
   localparam int VW = TAPS * W;

   if (W < 2 || TAPS < 1 || LAT < 1) begin : g_bad_cfg
      $error("rls_eq_seq: W>=2, TAPS>=1, LAT>=1 required");
   end
   if (INIT_DIAG < -(2 ** (W-1)) || INIT_DIAG >= 2 ** (W-1)) begin : g_bad_diag
      $error("rls_eq_seq: INIT_DIAG does not fit in W bits");
   end

   logic          init_pend_q;
   logic          accept;
   logic [VW-1:0] taps_nxt;
   arr_mode_e     mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) init_pend_q <= 1'b1;
      else        init_pend_q <= 1'b0;
   end

   assign accept = smp_valid & ~init_pend_q;

   eqs_tap_line #(.W(W), .TAPS(TAPS)) u_taps (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (accept),
      .din      (smp_data),
      .taps_nxt (taps_nxt)
   );

   eqs_row_former #(.W(W), .TAPS(TAPS), .INIT_DIAG(INIT_DIAG)) u_rows (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_fire (init_pend_q),
      .row_fire  (accept),
      .train     (train_mode),
      .taps_nxt  (taps_nxt),
      .sym       (train_sym),
      .row_valid (row_valid),
      .row_mode  (mode_q),
      .row_w1    (row_w1),
      .row_w2    (row_w2)
   );

   assign row_mode = mode_q;

   eqs_out_tracker #(.W(W), .LAT(LAT)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .lin_row  (row_valid && mode_q == MODE_LIN),
      .arr_y    (arr_y),
      .eq_valid (eq_valid),
      .eq_data  (eq_data)
   );

   p_init_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && mode_q == MODE_SET) |=> !(row_valid && mode_q == MODE_SET));
   p_init_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      init_pend_q |=> row_valid && mode_q == MODE_SET);
   p_row_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_pend_q && !smp_valid) |=> !row_valid);
endmodule

// File: tb/rls_eq_seq_tb_top.sv
module rls_eq_seq_tb_top;
   localparam int W = 16, TAPS = 4, LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [W-1:0] smp_data = '0;
   logic train_mode = 1'b0;
   logic [W-1:0] train_sym = '0;
   logic [W-1:0] arr_y;
   logic row_valid, eq_valid;
   logic [1:0] row_mode;
   logic [TAPS*W-1:0] row_w1;
   logic [W-1:0] row_w2, eq_data;

   logic r_valid, r_eqv;
   logic [1:0] r_mode;
   logic [TAPS*W-1:0] r_w1;
   logic [W-1:0] r_w2, r_eqd;

   int nchk = 0, nerr = 0;
   int hist [TAPS];

   always #5 clk = ~clk;

   rls_eq_seq #(.W(W), .TAPS(TAPS), .LAT(LAT), .INIT_DIAG(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .train_mode(train_mode), .train_sym(train_sym), .arr_y(arr_y),
      .row_valid(row_valid), .row_mode(row_mode), .row_w1(row_w1), .row_w2(row_w2),
      .eq_valid(eq_valid), .eq_data(eq_data));

   rls_eq_seq #(.W(W), .TAPS(TAPS), .LAT(LAT), .INIT_DIAG(5)) dut_reg_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(1'b0), .smp_data('0),
      .train_mode(1'b0), .train_sym('0), .arr_y('0),
      .row_valid(r_valid), .row_mode(r_mode), .row_w1(r_w1), .row_w2(r_w2),
      .eq_valid(r_eqv), .eq_data(r_eqd));

   // stand-in array: output = sum of W1 elements, LAT cycles after the row
   logic signed [W-1:0] st [LAT];
   logic signed [W-1:0] wsum;
   initial for (int i = 0; i < LAT; i++) st[i] = '0;
   always_comb begin
      wsum = '0;
      for (int k = 0; k < TAPS; k++) wsum = wsum + $signed(row_w1[k*W +: W]);
   end
   always_ff @(posedge clk) begin
      st[0] <= wsum;
      for (int i = 1; i < LAT; i++) st[i] <= st[i-1];
   end
   assign arr_y = st[LAT-1];

   task automatic chk(string req, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int el(int k);
      return int'($signed(row_w1[k*W +: W]));
   endfunction

   task automatic push_hist(int v);
      for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = v;
   endtask

   task automatic do_reset(bit smp_during_init, int v);
      rst_n = 1'b0; smp_valid = 1'b0;
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      repeat (3) @(negedge clk);
      chk("R2", "row_valid in reset", int'(row_valid), 0);
      chk("R7", "eq_valid in reset", int'(eq_valid), 0);
      smp_valid = smp_during_init; smp_data = W'(v); train_mode = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic t_init_row();
      do_reset(1'b0, 0);
      chk("R1", "set row valid", int'(row_valid), 1);
      chk("R1", "set row mode", int'(row_mode), 0);
      chk("R1", "set row w2", int'(row_w2), 0);
      for (int k = 0; k < TAPS; k++) chk("R1", "set row diag", el(k), 0);
      chk("R1", "sigma diag el0", int'($signed(r_w1[W-1:0])), 5);
      chk("R1", "sigma diag el3", int'($signed(r_w1[3*W +: W])), 5);
      chk("R1", "sigma mode", int'(r_mode), 0);
      @(negedge clk);
      chk("R1", "single set row", int'(row_valid), 0);
      chk("R1", "single sigma row", int'(r_valid), 0);
   endtask

   task automatic send_train(int v, int s);
      smp_valid = 1'b1; smp_data = W'(v); train_mode = 1'b1; train_sym = W'(s);
      @(negedge clk);
      smp_valid = 1'b0;
      push_hist(v);
      chk("R4", "orth mode", int'(row_mode), 1);
      chk("R4", "train sym on w2", int'($signed(row_w2)), s);
      chk("R7", "no eq for orth", int'(eq_valid), 0);
      for (int k = 0; k < TAPS; k++) chk("R3", "tap order", el(k), hist[k]);
   endtask

   task automatic t_zero_fill_train();
      send_train(3, 1);
      chk("R2", "leading zero tap1", el(1), 0);
      chk("R2", "leading zero tap3", el(3), 0);
      send_train(-7, -1);
      send_train(11, 1);
      send_train(2, -1);
      send_train(-4, 1);
      repeat (LAT + 1) begin
         @(negedge clk);
         chk("R7", "no eq after train", int'(eq_valid), 0);
      end
   endtask

   task automatic t_hold();
      int m, w2, e0;
      m = int'(row_mode); w2 = int'(row_w2); e0 = el(0);
      repeat (3) begin
         @(negedge clk);
         chk("R10", "idle no row", int'(row_valid), 0);
         chk("R6", "mode held", int'(row_mode), m);
         chk("R6", "w2 held", int'(row_w2), w2);
         chk("R6", "w1 held", el(0), e0);
      end
   endtask

   task automatic t_payload(int n, int base);
      int sums [$];
      for (int j = 0; j < n + LAT + 1; j++) begin
         if (j < n) begin
            smp_valid = 1'b1; smp_data = W'(base + 3*j); train_mode = 1'b0;
            train_sym = 16'd99;
         end else smp_valid = 1'b0;
         @(negedge clk);
         if (j < n) begin
            int s = 0;
            push_hist(base + 3*j);
            for (int k = 0; k < TAPS; k++) begin
               chk("R5", "negated tap", el(k), -hist[k]);
               s -= hist[k];
            end
            chk("R5", "lin mode", int'(row_mode), 2);
            chk("R5", "lin w2 zero", int'(row_w2), 0);
            sums.push_back(s);
         end
         if (j >= LAT && j - LAT < n) begin
            chk("R7", "eq_valid at LAT", int'(eq_valid), 1);
            chk("R8", "eq_data", int'($signed(eq_data)), sums[j-LAT]);
         end else begin
            chk("R7", "eq_valid off", int'(eq_valid), 0);
            chk("R8", "eq_data zero", int'(eq_data), 0);
         end
      end
   endtask

   task automatic t_switch_back();
      send_train(8, -1);
      t_payload(2, -20);
   endtask

   task automatic t_init_ignore();
      do_reset(1'b1, 77);
      chk("R9", "set row still issued", int'(row_mode), 0);
      @(negedge clk);
      chk("R9", "no row for dropped sample", int'(row_valid), 0);
      send_train(5, 1);
      chk("R9", "dropped sample not in line", el(1), 0);
   endtask

   initial begin
      #2_000_000;
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      t_init_row();
      t_zero_fill_train();
      t_hold();
      t_payload(6, 1);
      t_switch_back();
      t_init_ignore();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule